// File: doc/BRIEF.md
# Edge-Latched Interrupt Cause Unit

This block turns a vector of level status signals from a serial controller into a single interrupt request. Each status line is watched for a low-to-high change. Only that change latches the matching cause bit. A line that simply stays high never latches it again. A mask register selects which latched causes may drive the interrupt line, and the interrupt line is a registered level.

Software reaches three words through a small register port. The first is the live status levels, read-only. The second is the latched causes: reading returns them, and writing a one to a bit clears that bit. The third is the mask, which can be read and written. All three words use the same bit positions.

Because the live level stays readable apart from the latched edge, a driver can test the level first. It then arms the mask and waits only if the condition is not already true. The status signals come from the controller core and are taken as already synchronous to `clk`.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, the cause word and the mask word read 0 and `irq_o` is low.
- R2: A status bit that reads 0 in one cycle and 1 in the next sets its cause bit at that clock edge. The new cause is visible on a read in the cycle after the edge.
- R3: A status bit that stays high does not set its cause again, either after software clears the cause or when the line was already high through reset.
- R4: Writing to the cause word (address 1) clears each cause bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. Writing all ones clears every cause.
- R5: When a rising edge and a write-one-to-clear hit the same cause bit in the same cycle, the bit ends up set.
- R6: `irq_o` is registered. It goes high one clock after some cause bit and its mask bit are both 1, stays high while that holds, and goes low one clock after no enabled cause remains.
- R7: While the mask is all zeros, `irq_o` stays low whatever causes are latched.
- R8: Reading address 0 returns the live status levels, with this bit assignment: 0 transfer done, 1 transfer ready, 2 receive FIFO ready, 3 transmit FIFO ready, 4 receive empty, 5 receive full, 6 transmit empty, 7 transmit full, 8 receive underflow, 9 receive overflow, 10 transmit underflow, 11 transmit overflow.
- R9: The mask word (address 2) reads back the last value written to it. Cause and mask bits use the same positions as the status word, so status bit k latches cause bit k and is enabled by mask bit k.
- R10: Writes to address 0 and to address 3 change neither the cause word nor the mask word, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status_i | input | N_SRC | Live level status signals from the controller core |
| reg_addr | input | 2 | Word select: 0 level, 1 cause, 2 mask, 3 reserved |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | N_SRC | Write data |
| reg_rdata | output | N_SRC | Read data for the selected word, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with the default width of twelve status lines. Every named bit position can therefore be driven, up to the transmit overflow flag in bit 11, and the bench confirms that the highest bit latches and unmasks in its own position. With the full width, all-ones clears and multi-bit patterns also cover the whole word. The bench further exercises the same-cycle race between an edge and a clear, and a line held high through reset.

// File: rtl/irq_cause_pkg.sv
// Shared definitions for the interrupt cause unit: the word select codes
// of the register port. Assumes a two-bit address.
package irq_cause_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LEVEL = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_RSVD  = 2'd3
    } word_sel_e;
endpackage

// File: rtl/irq_rise_detect.sv
// Rising-edge detector for a vector of level signals. It keeps the previous
// sample of each line and flags the lines that read 0 before and 1 now.
// Assumes the inputs are synchronous to clk. During reset the history follows
// the inputs, so a line already high when reset ends gives no edge.
module irq_rise_detect #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Keep the previous sample, loaded from the live lines in reset as well.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= level_i;
        else        prev_q <= level_i;
    end

    // An edge is a line that is high now and was low one cycle before.
    always_comb rise_o = level_i & ~prev_q;
endmodule

// File: rtl/irq_cause_bank.sv
// Bank of latched cause bits, one per status line. A rising edge sets a
// bit and a clear request resets it. When both arrive in the same cycle,
// the set wins. Assumes the clear vector is already qualified by the write
// strobe.
module irq_cause_bank #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cause_o
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic bit_q;

            // One cause flag: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)        bit_q <= 1'b0;
                else if (set_i[i]) bit_q <= 1'b1;
                else if (clr_i[i]) bit_q <= 1'b0;
            end

            assign cause_o[i] = bit_q;
        end
    endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
// Read/write enable mask for the cause bits. It loads the write data when
// the load strobe is high and resets to all zeros, which blocks everything.
module irq_mask_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;

    // Hold the enable pattern until software rewrites it.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (load_i) mask_q <= data_i;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irq_cause_unit.sv
// Interrupt cause unit for a serial controller. It latches causes on the
// rising edges of the status lines, gates them with a mask into one
// registered interrupt level, and offers the level, cause and mask words on
// a simple register port. Assumes status_i is synchronous to clk and that
// reads have no side effects.
module irq_cause_unit
    import irq_cause_pkg::*;
#(
    parameter int N_SRC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  status_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [N_SRC-1:0]  reg_wdata,
    output logic [N_SRC-1:0]  reg_rdata,
    output logic              irq_o
);
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] clr_req;
    logic [N_SRC-1:0] cause_q;
    logic [N_SRC-1:0] mask_q;
    logic             wr_cause;
    logic             wr_mask;
    logic             irq_q;

    // Decode the write strobes for the two writable words.
    always_comb begin
        wr_cause = reg_wr && (reg_addr == SEL_CAUSE);
        wr_mask  = reg_wr && (reg_addr == SEL_MASK);
        clr_req  = wr_cause ? reg_wdata : '0;
    end

    irq_rise_detect #(.W(N_SRC)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (status_i),
        .rise_o  (rise)
    );

    irq_cause_bank #(.W(N_SRC)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (rise),
        .clr_i   (clr_req),
        .cause_o (cause_q)
    );

    irq_mask_reg #(.W(N_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wr_mask),
        .data_i (reg_wdata),
        .mask_o (mask_q)
    );

    // Register the OR of the enabled causes as the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(cause_q & mask_q);
    end

    assign irq_o = irq_q;

    // Select the read word; the reserved slot reads zero.
    always_comb begin
        case (reg_addr)
            SEL_LEVEL: reg_rdata = status_i;
            SEL_CAUSE: reg_rdata = cause_q;
            SEL_MASK:  reg_rdata = mask_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_cause_unit_chk.sv
// Property checker for irq_cause_unit, attached by bind. It watches the
// ports and the edge, cause and mask state across cycles.
module irq_cause_unit_chk
    import irq_cause_pkg::*;
#(
    parameter int N_SRC = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  status_i,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [N_SRC-1:0]  reg_wdata,
    input logic              irq_o,
    input logic [N_SRC-1:0]  rise,
    input logic [N_SRC-1:0]  cause_q,
    input logic [N_SRC-1:0]  mask_q
);
    logic past_ok;

    // Mark the cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) && rst_n |-> (cause_q == '0) && (mask_q == '0) && !irq_o);

    // R2
    cause_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((cause_q & ~$past(cause_q) & ~$past(status_i)) == '0));

    // R5
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (($past(rise) & ~cause_q) == '0));

    // R4
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_wr && (reg_addr == SEL_CAUSE))
        |-> ((cause_q & $past(reg_wdata) & ~$past(rise)) == '0));

    // R6
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (irq_o == $past(|(cause_q & mask_q))));

    // R7
    zero_mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mask_q == '0) |-> !irq_o);

    // R9
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_wr && (reg_addr == SEL_MASK)) |-> (mask_q == $past(reg_wdata)));

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(reg_wr && (reg_addr == SEL_MASK)) |-> $stable(mask_q));
endmodule

bind irq_cause_unit irq_cause_unit_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_i  (status_i),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .rise      (rise),
    .cause_q   (cause_q),
    .mask_q    (mask_q)
);

// File: tb/irq_cause_unit_tb.sv
// Directed bench for irq_cause_unit: one task per scenario. Inputs change
// and outputs are sampled just after the falling clock edge.
module irq_cause_unit_tb;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] status_i = '0;
    logic [1:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_cause_unit #(.N_SRC(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_i  (status_i),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    // R1, R3: reset values, and a line held high through reset latches nothing.
    task automatic t_reset();
        logic [N-1:0] v;
        status_i = 12'h001;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        rd(2'd1, v); chk("R1 cause after reset", v, '0);
        rd(2'd2, v); chk("R1 mask after reset", v, '0);
        chk("R1 irq after reset", {11'd0, irq_o}, '0);
        step();
        rd(2'd1, v); chk("R3 high through reset", v, '0);
    endtask

    // R2, R3: an edge sets its cause; a held level does not set it again.
    task automatic t_rise_and_hold();
        logic [N-1:0] v;
        status_i = 12'h009;
        step();
        rd(2'd1, v); chk("R2 edge on bit3", v, 12'h008);
        wr(2'd1, 12'h008);
        rd(2'd1, v); chk("R4 clear bit3", v, '0);
        repeat (3) step();
        rd(2'd1, v); chk("R3 held level no reset", v, '0);
        status_i = 12'h001;
        step();
        status_i = 12'h009;
        step();
        rd(2'd1, v); chk("R2 second edge on bit3", v, 12'h008);
    endtask

    // R4: partial and full write-one-to-clear.
    task automatic t_w1c();
        logic [N-1:0] v;
        status_i = 12'h0A9;
        step();
        rd(2'd1, v); chk("R2 edges on bits5,7", v, 12'h0A8);
        wr(2'd1, 12'h020);
        rd(2'd1, v); chk("R4 partial clear", v, 12'h088);
        wr(2'd1, 12'hFFF);
        rd(2'd1, v); chk("R4 clear all", v, '0);
    endtask

    // R5: an edge in the same cycle as a clear of that bit leaves it set.
    task automatic t_priority();
        logic [N-1:0] v;
        status_i = 12'h001;
        step();
        status_i = 12'h009;
        wr(2'd1, 12'h008);
        rd(2'd1, v); chk("R5 set beats clear", v, 12'h008);
    endtask

    // R6, R7, R9: mask gating and registered interrupt timing.
    task automatic t_irq();
        logic [N-1:0] v;
        repeat (3) step();
        chk("R7 zero mask blocks irq", {11'd0, irq_o}, '0);
        wr(2'd2, 12'h008);
        rd(2'd2, v); chk("R9 mask readback", v, 12'h008);
        chk("R6 irq one cycle late", {11'd0, irq_o}, '0);
        step();
        chk("R6 irq rises", {11'd0, irq_o}, 12'h001);
        repeat (2) step();
        chk("R6 irq stays high", {11'd0, irq_o}, 12'h001);
        wr(2'd1, 12'h008);
        chk("R6 irq still high one cycle", {11'd0, irq_o}, 12'h001);
        step();
        chk("R6 irq falls", {11'd0, irq_o}, '0);
    endtask

    // R9: the top bit latches and unmasks in its own position.
    task automatic t_top_bit();
        logic [N-1:0] v;
        wr(2'd2, 12'h800);
        status_i = 12'h809;
        step();
        rd(2'd1, v); chk("R9 bit11 cause position", v, 12'h800);
        step();
        chk("R9 bit11 unmasks irq", {11'd0, irq_o}, 12'h001);
        wr(2'd1, 12'hFFF);
        step();
    endtask

    // R8, R10: live level read, and writes to level/reserved have no effect.
    task automatic t_level_and_ignored();
        logic [N-1:0] v;
        logic [N-1:0] c0;
        status_i = 12'hABC;
        step();
        rd(2'd0, v); chk("R8 live level", v, 12'hABC);
        rd(2'd1, c0);
        wr(2'd0, 12'hFFF);
        wr(2'd3, 12'hFFF);
        rd(2'd0, v); chk("R8 level after writes", v, 12'hABC);
        rd(2'd1, v); chk("R10 cause untouched", v, c0);
        rd(2'd2, v); chk("R10 mask untouched", v, 12'h800);
        rd(2'd3, v); chk("R10 reserved reads zero", v, '0);
    endtask

    initial begin
        t_reset();
        t_rise_and_hold();
        t_w1c();
        t_priority();
        t_irq();
        t_top_bit();
        t_level_and_ignored();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule